// File: doc/BRIEF.md
# Iterative Logical Shifter with Valid/Ready Ports

This block shifts a data word left or right by a requested number of bit positions, one position per clock cycle, using a small state machine instead of a single-cycle barrel network. A producer offers a job (word, shift amount, direction) on the input side through a valid/ready handshake. A consumer takes the shifted word from the output side through a second valid/ready handshake.

The unit handles one job at a time. It accepts a job only while idle. It then steps through the shift and presents the result, which it holds until the consumer takes it. Only logical shifts are performed: bits that leave the word are lost and zeros fill the vacated positions. The number of stepping cycles is capped at the word width, because any longer shift already yields zero.

Top module: `iter_shifter`

## Requirements
- R1: After reset, `src_ready` is 1 and `res_valid` is 0.
- R2: `src_ready` and `res_valid` are never high in the same cycle. A job is accepted only on a clock edge where `src_valid` and `src_ready` are both 1.
- R3: With `src_dir` = 1, the result is the word shifted right logically by the amount, with zeros entering at the most significant bit (13 by 2 gives 3).
- R4: With `src_dir` = 0, the result is the word shifted left logically by the amount, with zeros entering at bit 0 (3 by 4 gives 48).
- R5: An amount of 0 returns the word unchanged (21 gives 21). `res_valid` is high in the first cycle after the accepting edge.
- R6: An amount of WIDTH (8) or more gives a zero result after exactly WIDTH stepping cycles.
- R7: `res_valid` rises min(amount, WIDTH) clock edges after the accepting edge.
- R8: While `res_valid` is 1 and `res_ready` is 0, the next cycle still has `res_valid` at 1 and an unchanged `res_word`.
- R9: The edge where `res_valid` and `res_ready` are both 1 returns the unit to idle: in the next cycle `src_ready` is 1 and `res_valid` is 0.
- R10: Word and amount values offered while the unit is busy, with `src_valid` held high, have no effect on the result of the job in progress.
- R11: The direction is captured at the accepting edge. Changing `src_dir` afterwards does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Producer offers a job |
| src_ready | output | 1 | Unit is idle and can take a job |
| src_word | input | WIDTH | Word to shift |
| src_count | input | AMT_W | Number of positions to shift |
| src_dir | input | 1 | 1 = right, 0 = left |
| res_valid | output | 1 | Shifted word is available |
| res_ready | input | 1 | Consumer takes the word |
| res_word | output | WIDTH | Shifted word |

## Verification
A result is due min(amount, 8) edges after the accepting edge, so a zero shift is visible at the first sample after acceptance and any amount of 8 or more takes eight steps. The bench samples and drives on falling edges and counts these falling edges from acceptance until `res_valid` appears, so it compares the measured latency with that count as well as the word. It then holds `res_ready` low for a random number of cycles to check that the result stays put. After the taking edge, it checks idle at the very next sample.

// File: rtl/iter_shifter.sv
module iter_shifter #(
  parameter int WIDTH = 8,
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic [WIDTH-1:0] src_word,
  input  logic [AMT_W-1:0] src_count,
  input  logic             src_dir,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WIDTH-1:0] res_word
);
  localparam int CW = $clog2(WIDTH + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_HOLD} st_t;

  st_t             st;
  logic [WIDTH-1:0] word;
  logic [CW-1:0]    left;
  logic             right;
  logic [CW-1:0]    start_left;
  logic [WIDTH-1:0] stepped;

  assign start_left = (src_count >= AMT_W'(WIDTH)) ? CW'(WIDTH) : src_count[CW-1:0];
  assign stepped    = right ? {1'b0, word[WIDTH-1:1]} : {word[WIDTH-2:0], 1'b0};
  assign src_ready  = (st == ST_IDLE);
  assign res_valid  = (st == ST_HOLD);
  assign res_word   = word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      word  <= '0;
      left  <= '0;
      right <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (src_valid) begin
          word  <= src_word;
          left  <= start_left;
          right <= src_dir;
          st    <= (start_left == '0) ? ST_HOLD : ST_STEP;
        end
        ST_STEP: begin
          word <= stepped;
          left <= left - 1'b1;
          if (left == CW'(1)) st <= ST_HOLD;
        end
        ST_HOLD: if (res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_ready && res_valid)); // R2
  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready && src_count == '0) |=> res_valid); // R5
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    left <= CW'(WIDTH)); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_word))); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (src_ready && !res_valid)); // R9
endmodule

// File: tb/iter_shifter_test.sv
module iter_shifter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_valid = 1'b0;
  logic       src_ready;
  logic [7:0] src_word = '0;
  logic [7:0] src_count = '0;
  logic       src_dir = 1'b0;
  logic       res_valid;
  logic       res_ready = 1'b0;
  logic [7:0] res_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  iter_shifter #(.WIDTH(8), .AMT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_word(src_word), .src_count(src_count), .src_dir(src_dir),
    .res_valid(res_valid), .res_ready(res_ready), .res_word(res_word));

  function automatic logic [7:0] model(logic [7:0] d, logic [7:0] n, logic r);
    if (n >= 8) return 8'h00;
    return r ? (d >> n) : (d << n);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic job(logic [7:0] d, logic [7:0] n, logic r, int hold);
    int lat = 0;
    logic [7:0] exp = model(d, n, r);
    int exp_lat = (n >= 8) ? 8 : int'(n);
    string tag = r ? "R3" : "R4";
    if (n == 0) tag = "R5";
    else if (n >= 8) tag = "R6";
    @(negedge clk);
    check("R2 idle ready", int'(src_ready), 1);
    src_valid = 1'b1; src_word = d; src_count = n; src_dir = r;
    @(negedge clk);
    // R10 R11: junk offered while busy
    src_word = ~d; src_count = 8'd1; src_dir = ~r;
    while (!res_valid && lat < 20) begin
      check("R2 busy not ready", int'(src_ready), 0);
      @(negedge clk);
      lat++;
    end
    check("R7 latency", lat, exp_lat);
    check({tag, " R10 R11 result"}, int'(res_word), int'(exp));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R8 valid held", int'(res_valid), 1);
      check("R8 word held", int'(res_word), int'(exp));
    end
    src_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check("R9 released", int'(res_valid), 0);
    check("R9 idle", int'(src_ready), 1);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 ready after reset", int'(src_ready), 1);
    check("R1 valid after reset", int'(res_valid), 0);
    rst_n = 1'b1;
    job(8'd13, 8'd2, 1'b1, 0);
    job(8'd3, 8'd4, 1'b0, 2);
    job(8'd21, 8'd0, 1'b0, 1);
    job(8'hFF, 8'd7, 1'b1, 0);
    job(8'hFF, 8'd7, 1'b0, 0);
    job(8'hA5, 8'd8, 1'b1, 0);
    job(8'hA5, 8'd255, 1'b0, 3);
    job(8'h81, 8'd1, 1'b0, 0);
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d = 8'($urandom);
      logic [7:0] n = ($urandom % 5 == 0) ? 8'($urandom) : 8'($urandom % 10);
      job(d, n, 1'($urandom), int'($urandom % 4));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule